// File: doc/BRIEF.md
# I2C Master Repeated-Start Generator

This block is the bus-condition engine of an I2C master. It drives open-drain SDA and SCL through two output enables: an enable of 1 pulls the line low, and 0 releases it. It reads both lines back through a one-flop input sample. Software launches a bus condition by writing a five-bit command register. Bit 0 requests a Start, bit 1 a Repeated Start and bit 2 a Stop. Bits 4:3 are plain stored command bits.

Every phase of a sequence lasts one baud period of `reload`+1 clock cycles. A down-counter is loaded with `reload` on entry to the phase and counts to zero. Phases that wait on the bus advance only on sampled line levels. A device stretching SCL low therefore simply holds the sequence. The timer restarts only once the high level has been seen.

While a sequence runs, or a request is still pending, the command register and the transmit holding register refuse writes. A refused transmit write raises a write-collision flag. During a Repeated Start the block watches for another master:
- SDA low while SCL is high.
- SCL pulled low before SDA has been driven low.

Either case raises a sticky bus-collision flag, releases both lines and abandons the request. A start-detected status bit follows the conditions seen on the lines. An interrupt flag marks the end of each completed sequence.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset both output enables are 0, `cmd_q` and `tx_q` are 0, and `start_seen`, `irq`, `wcol` and `bcol` are 0.
- R2: A command write takes effect only when no sequence is active and `cmd_q[2:0]` is 0. Otherwise the whole write, including bits 4:3, is ignored. Bit 0 requests a Start, bit 1 a Repeated Start and bit 2 a Stop.
- R3: An accepted Repeated Start first drives SCL low and keeps SDA as it was. Two cycles later, once SCL is sampled low, it releases SDA with SCL still low for `reload`+1 cycles, and never fewer than 2. If SDA was already released, the span of released SDA with SCL driven low is therefore `reload`+3 cycles.
- R4: SCL is released only when SDA is sampled high. Time spent with SCL held low by another device is not counted. SDA is driven low exactly `reload`+3 cycles after the first cycle in which the SCL line is high.
- R5: SDA stays driven low with SCL released for `reload`+1 cycles. Then `irq` sets, `cmd_q[1]` clears, the counter stops and SDA remains driven low.
- R6: `start_seen` sets two cycles after SDA falls while SCL is high. It clears two cycles after SDA rises while SCL is high.
- R7: A transmit write while busy sets `wcol` and leaves `tx_q` unchanged. While idle it loads `tx_q` and leaves `wcol` untouched.
- R8: During a Repeated Start, SDA sampled low when SCL is seen to go high, or while both lines should be high, is a bus collision.
- R9: During a Repeated Start, SCL sampled low in the phase where both lines should be high, before SDA is driven low, is a bus collision.
- R10: A bus collision releases both lines, clears `cmd_q[1]`, sets `bcol` and returns to idle. The flags clear only through `flag_clr` (bit 0 `irq`, bit 1 `wcol`, bit 2 `bcol`); a set in the same cycle wins.
- R11: A Start drives SDA low with SCL released for `reload`+1 cycles, then sets `irq` and keeps SDA low. A Stop ends with both lines released, `irq` set and `start_seen` cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command write data |
| cmd_q | output | 5 | Command register contents |
| reload | input | BRG_W | Baud counter reload value |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | DATA_W | Transmit write data |
| tx_q | output | DATA_W | Transmit holding register contents |
| flag_clr | input | 3 | Flag clear strobes: irq, wcol, bcol |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| start_seen | output | 1 | Start condition observed on the lines |
| irq | output | 1 | Sequence complete flag |
| wcol | output | 1 | Write collision flag |
| bcol | output | 1 | Bus collision flag |

## Verification
The bench runs random Repeated Starts with and without SDA already held low, across reload values and SCL stretches of up to 40 cycles. It measures each phase in cycles. A design that starts its timer before SCL is seen high would drive SDA low early under stretching. One that ignores the held SDA level would miscount the first phase.

Directed cases do the following:
- Write commands and transmit data mid-sequence. A design without the lockout would launch queued events or corrupt `tx_q`.
- Force SDA low at the SCL rising edge, and force SCL low during the both-high phase. A design that misses either case would go on to drive a bogus Start.
- Check that the collision flag survives until it is cleared.

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen #(
  parameter int BRG_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [4:0]        cmd_wdata,
  output logic [4:0]        cmd_q,
  input  logic [BRG_W-1:0]  reload,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [DATA_W-1:0] tx_q,
  input  logic [2:0]        flag_clr,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              start_seen,
  output logic              irq,
  output logic              wcol,
  output logic              bcol
);

  localparam logic [BRG_W-1:0] BRG_ONE = 1;

  typedef enum logic [3:0] {
    IDLE, ST_HOLD,
    RS_SCL_LO, RS_SDA_HI, RS_SCL_REL, RS_SETUP, RS_HOLD,
    SP_LOW, SP_SCL_REL, SP_SETUP, SP_SDA_REL
  } st_t;

  st_t              st;
  logic [BRG_W-1:0] brg;
  logic             sda_s, scl_s, sda_p, scl_p, sda_hold;

  wire busy     = (st != IDLE) || (|cmd_q[2:0]);
  wire brg_zero = (brg == '0);
  wire col_a    = (st == RS_SCL_REL && scl_s && !sda_s) || (st == RS_SETUP && !sda_s);
  wire col_b    = (st == RS_SETUP && !scl_s);

  always_comb begin
    sda_oe = 1'b0;
    scl_oe = 1'b0;
    case (st)
      IDLE:       sda_oe = sda_hold;
      ST_HOLD:    sda_oe = 1'b1;
      RS_SCL_LO:  begin sda_oe = sda_hold; scl_oe = 1'b1; end
      RS_SDA_HI:  scl_oe = 1'b1;
      RS_HOLD:    sda_oe = 1'b1;
      SP_LOW:     begin sda_oe = 1'b1; scl_oe = 1'b1; end
      SP_SCL_REL: sda_oe = 1'b1;
      SP_SETUP:   sda_oe = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      brg <= '0;
      cmd_q <= '0;
      tx_q <= '0;
      sda_s <= 1'b1;
      scl_s <= 1'b1;
      sda_p <= 1'b1;
      scl_p <= 1'b1;
      sda_hold <= 1'b0;
      start_seen <= 1'b0;
      irq <= 1'b0;
      wcol <= 1'b0;
      bcol <= 1'b0;
    end else begin
      sda_s <= sda_in;
      scl_s <= scl_in;
      sda_p <= sda_s;
      scl_p <= scl_s;
      if (sda_p && !sda_s && scl_p && scl_s) start_seen <= 1'b1;
      else if (!sda_p && sda_s && scl_p && scl_s) start_seen <= 1'b0;

      if (flag_clr[0]) irq <= 1'b0;
      if (flag_clr[1]) wcol <= 1'b0;
      if (flag_clr[2]) bcol <= 1'b0;

      if (tx_wr) begin
        if (busy) wcol <= 1'b1;
        else      tx_q <= tx_wdata;
      end
      if (cmd_wr && !busy) cmd_q <= cmd_wdata;

      if (col_a || col_b) begin
        st <= IDLE;
        sda_hold <= 1'b0;
        cmd_q[1] <= 1'b0;
        bcol <= 1'b1;
      end else begin
        case (st)
          IDLE: begin
            if (cmd_q[0]) begin
              st <= ST_HOLD;
              brg <= reload;
              cmd_q[2:1] <= 2'b00;
            end else if (cmd_q[1]) begin
              st <= RS_SCL_LO;
              cmd_q[2] <= 1'b0;
            end else if (cmd_q[2]) begin
              st <= SP_LOW;
              brg <= reload;
            end
          end
          ST_HOLD: begin
            if (brg_zero) begin
              st <= IDLE;
              cmd_q[0] <= 1'b0;
              irq <= 1'b1;
              sda_hold <= 1'b1;
            end else brg <= brg - BRG_ONE;
          end
          RS_SCL_LO: begin
            if (!scl_s) begin
              st <= RS_SDA_HI;
              brg <= reload;
              sda_hold <= 1'b0;
            end
          end
          RS_SDA_HI: begin
            if (!brg_zero) brg <= brg - BRG_ONE;
            else if (sda_s) st <= RS_SCL_REL;
          end
          RS_SCL_REL: begin
            if (scl_s) begin
              st <= RS_SETUP;
              brg <= reload;
            end
          end
          RS_SETUP: begin
            if (brg_zero) begin
              st <= RS_HOLD;
              brg <= reload;
            end else brg <= brg - BRG_ONE;
          end
          RS_HOLD: begin
            if (brg_zero) begin
              st <= IDLE;
              cmd_q[1] <= 1'b0;
              irq <= 1'b1;
              sda_hold <= 1'b1;
            end else brg <= brg - BRG_ONE;
          end
          SP_LOW: begin
            if (brg_zero) st <= SP_SCL_REL;
            else brg <= brg - BRG_ONE;
          end
          SP_SCL_REL: begin
            if (scl_s) begin
              st <= SP_SETUP;
              brg <= reload;
            end
          end
          SP_SETUP: begin
            if (brg_zero) begin
              st <= SP_SDA_REL;
              brg <= reload;
              sda_hold <= 1'b0;
            end else brg <= brg - BRG_ONE;
          end
          SP_SDA_REL: begin
            if (brg_zero) begin
              st <= IDLE;
              cmd_q[2] <= 1'b0;
              irq <= 1'b1;
            end else brg <= brg - BRG_ONE;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R2
  cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(cmd_q[4:3]));

  // R7
  tx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && busy) |=> (wcol && $stable(tx_q)));

  // R4
  scl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && !sda_oe) |-> $past(sda_s));

  // R5
  rs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == RS_HOLD && st == IDLE) |-> (irq && sda_oe && !scl_oe && !cmd_q[1]));

  // R9
  col_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_SETUP && !scl_s) |=> (bcol && st == IDLE && !sda_oe && !scl_oe));

  // R10
  bcol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcol && !flag_clr[2]) |=> bcol);

endmodule

// File: tb/i2c_rstart_gen_bench.sv
`timescale 1ns/1ps
module i2c_rstart_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd_wdata = '0;
  logic [4:0] cmd_q;
  logic [6:0] reload = '0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic [7:0] tx_q;
  logic [2:0] flag_clr = '0;
  logic       sda_oe, scl_oe, start_seen, irq, wcol, bcol;
  logic       ext_sda = 1'b0, ext_scl = 1'b0;
  wire        sda_in = !(sda_oe || ext_sda);
  wire        scl_in = !(scl_oe || ext_scl);
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  i2c_rstart_gen u_i2c_rstart_gen (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .reload(reload), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_q(tx_q), .flag_clr(flag_clr),
    .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .start_seen(start_seen), .irq(irq), .wcol(wcol), .bcol(bcol));

  function automatic int exp_lo(int rl, bit held);
    if (!held) return rl + 3;
    return (rl < 1) ? 2 : rl + 1;
  endfunction
  function automatic int exp_su(int rl);
    return rl + 3;
  endfunction
  function automatic int exp_hold(int rl);
    return rl + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [4:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic wait_irq();
    int g = 0;
    while (!irq && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(input int rl, input bit timed);
    int cnt = 0, g = 0;
    reload = 7'(rl);
    cmd(5'b00001);
    while (!irq && g < 5000) begin
      if (sda_oe) cnt++;
      @(negedge clk); g++;
    end
    if (timed) begin
      chk("R11 start SDA-low span", cnt, rl + 1);
      chk("R11 start SDA kept low", int'(sda_oe), 1);
    end
    clr(3'b001);
  endtask

  task automatic do_stop(input int rl);
    reload = 7'(rl);
    cmd(5'b00100);
    wait_irq();
    wait_n(3);
    chk("R11 stop lines released", int'({sda_oe, scl_oe}), 0);
    chk("R6 stop clears start_seen", int'(start_seen), 0);
    clr(3'b001);
  endtask

  task automatic rs_run(input int rl, input bit held, input int stretch);
    int g = 0, lo = 0, su = 0, irq_k = -1, ss_k = -1;
    reload = 7'(rl);
    cmd(5'b00010);
    while (!scl_oe && g < 100) begin @(negedge clk); g++; end
    if (stretch > 0) ext_scl = 1'b1;
    while (scl_oe && g < 5000) begin
      if (!sda_oe) lo++;
      @(negedge clk); g++;
    end
    for (int i = 0; i < stretch; i++) begin
      if (sda_oe) su = -1000;
      @(negedge clk);
    end
    ext_scl = 1'b0;
    while (!sda_oe && g < 5000) begin @(negedge clk); su++; g++; end
    for (int k = 0; k < rl + 6; k++) begin
      if (irq && irq_k < 0) irq_k = k;
      if (start_seen && ss_k < 0) ss_k = k;
      @(negedge clk);
    end
    chk("R3 SDA released with SCL low", lo, exp_lo(rl, held));
    chk("R4 SCL high to SDA low", su, exp_su(rl));
    chk("R5 SDA-low hold before irq", irq_k, exp_hold(rl));
    chk("R6 start_seen delay", ss_k, held ? 0 : 2);
    chk("R5 end state lines and request", int'({sda_oe, scl_oe, cmd_q}), 64);
    clr(3'b001);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 output enables", int'({sda_oe, scl_oe}), 0);
    chk("R1 cmd_q", int'(cmd_q), 0);
    chk("R1 tx_q", int'(tx_q), 0);
    chk("R1 flags", int'({start_seen, irq, wcol, bcol}), 0);

    // R7 idle transmit write
    @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'h3C;
    @(negedge clk); tx_wr = 1'b0;
    chk("R7 idle write loads tx_q", int'(tx_q), 8'h3C);
    chk("R7 idle write leaves wcol", int'(wcol), 0);

    // R11 start then stop
    do_start(3, 1'b1);
    wait_n(2);
    chk("R6 start_seen after Start", int'(start_seen), 1);
    do_stop(2);

    // R2 and R7 lockout during a Repeated Start
    reload = 7'd20;
    cmd(5'b00010);
    wait_n(6);
    cmd_wr = 1'b1; cmd_wdata = 5'b11101; tx_wr = 1'b1; tx_wdata = 8'hA5;
    @(negedge clk); cmd_wr = 1'b0; tx_wr = 1'b0;
    chk("R2 busy command write ignored", int'(cmd_q), 5'b00010);
    chk("R7 busy write keeps tx_q", int'(tx_q), 8'h3C);
    chk("R7 busy write sets wcol", int'(wcol), 1);
    wait_irq();
    wait_n(10);
    chk("R2 no queued event launched", int'({sda_oe, scl_oe, cmd_q}), 64);
    clr(3'b011);
    chk("R10 flag clear", int'({irq, wcol}), 0);

    // R2 request during Start has no effect
    do_stop(1);
    reload = 7'd10;
    cmd(5'b00001);
    wait_n(3);
    cmd(5'b00010);
    wait_irq();
    wait_n(8);
    chk("R2 request during Start dropped", int'({scl_oe, cmd_q}), 0);
    clr(3'b001);

    // R8 SDA low as SCL rises
    do_stop(1);
    reload = 7'd5;
    cmd(5'b00010);
    while (!scl_oe) @(negedge clk);
    while (scl_oe) @(negedge clk);
    ext_sda = 1'b1;
    wait_n(4);
    chk("R8 collision flag", int'(bcol), 1);
    chk("R10 lines released and request cleared", int'({sda_oe, scl_oe, cmd_q}), 0);
    ext_sda = 1'b0;
    wait_n(5);
    chk("R10 bcol sticky", int'(bcol), 1);
    clr(3'b100);
    chk("R10 bcol cleared", int'(bcol), 0);

    // R9 SCL pulled low before SDA driven low
    reload = 7'd15;
    cmd(5'b00010);
    while (!scl_oe) @(negedge clk);
    while (scl_oe) @(negedge clk);
    wait_n(4);
    ext_scl = 1'b1;
    wait_n(4);
    chk("R9 collision flag", int'(bcol), 1);
    chk("R9 lines released and request cleared", int'({sda_oe, scl_oe, cmd_q}), 0);
    ext_scl = 1'b0;
    clr(3'b101);

    // random Repeated Starts
    for (int it = 0; it < 30; it++) begin
      int rl = $urandom_range(0, 12);
      bit held = 1'($urandom_range(0, 1));
      int stretch = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 40) : 0;
      if (held) do_start($urandom_range(0, 6), 1'b0);
      else do_stop($urandom_range(0, 6));
      rs_run(rl, held, stretch);
    end

    // directed extremes of reload
    do_stop(0);
    rs_run(0, 1'b0, 0);
    do_start(0, 1'b0);
    rs_run(0, 1'b1, 7);
    do_stop(3);
    rs_run(127, 1'b0, 3);

    finish_up();
  end
endmodule